// File: doc/BRIEF.md
# DMA Request Source Selector

This block forms the single transfer request that one DMA channel hands to its channel sequencer. The request can come from three places: an external request pin, one of the on-chip peripheral interrupt lines, or a software trigger bit. A source-select field picks the hardware origin. A transfer-type field decides how the external pin is read: edges for block, step and burst transfers, levels for demand transfers. The software trigger is OR'ed into the request whatever the other two fields hold.

The external pin first passes through a synchroniser. An edge on the pin is held as a pending request until the sequencer acknowledges it. A level request follows the synchronised pin cycle by cycle and is not held. A peripheral line passes straight through while its code is selected. The software trigger bit stays set until an acknowledge clears it.

The edge path is a three-state machine. `EX_OFF` is the idle state when the edge mode is not selected. `EX_WATCH` waits for the chosen edge. `EX_PEND` holds the request. Its transitions are:
- `EX_OFF -> EX_WATCH` when the edge mode becomes selected.
- `EX_WATCH -> EX_PEND` on the selected edge.
- `EX_PEND -> EX_WATCH` on an acknowledge with no new edge in the same cycle.
- Any state goes to `EX_OFF` when the edge mode is deselected.

The software path has two states. `SW_IDLE` goes to `SW_ARMED` on a trigger write. `SW_ARMED` goes back to `SW_IDLE` on an acknowledge with no write in the same cycle.

Top module: `dma_req_select`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `dma_req` is 0.
- R2: With `src_sel` = 5'b01110 and `xfer_type` in block (2'b00), step (2'b01) or burst (2'b10), a falling edge on `ext_pin` raises `dma_req` after the third rising clock edge following the pin change. The request then stays high until acknowledged. A rising edge in this mode creates no request.
- R3: With `src_sel` = 5'b01111 and a non-demand `xfer_type`, a rising edge on `ext_pin` raises `dma_req` with the same three-edge latency and holding. A falling edge creates no request.
- R4: A one-cycle `req_ack` clears a pending edge request, and `dma_req` is 0 in the cycle after the acknowledging edge.
- R5: With `xfer_type` = demand (2'b11) and `src_sel` = 5'b01110, `dma_req` equals the level of `ext_pin` delayed by two rising edges (high means request). `req_ack` does not lower it.
- R6: With demand and `src_sel` = 5'b01111, `dma_req` equals the inverted level of `ext_pin` delayed by two rising edges.
- R7: With `src_sel[4]` = 1, `dma_req` follows `periph_irq[src_sel[3:0]]` in the same cycle. The other peripheral lines and `ext_pin` have no effect.
- R8: With any `src_sel` other than 5'b01110, 5'b01111 or 5'b1xxxx, neither `ext_pin` nor `periph_irq` can raise `dma_req`.
- R9: A one-cycle `sw_trig_wr` pulse raises `dma_req` from the next rising edge under any source setting. The request holds until `req_ack`, and the cycle after the acknowledging edge is 0.
- R10: When `sw_trig_wr` and `req_ack` are high in the same cycle, the software request stays set.
- R11: Leaving the edge mode discards a pending edge request at once. Returning to that mode does not bring the request back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 5 | Source-select code |
| xfer_type | input | 2 | 00 block, 01 step, 10 burst, 11 demand |
| ext_pin | input | 1 | Asynchronous external request pin |
| periph_irq | input | 16 | Peripheral interrupt lines |
| sw_trig_wr | input | 1 | One-cycle write that sets the software trigger bit |
| req_ack | input | 1 | Acknowledge from the channel sequencer |
| dma_req | output | 1 | Transfer request to the channel sequencer |

## Verification
The bench checks the three-edge latency of edge requests and the two-edge latency of level requests. A design with a missing or extra synchroniser stage would sample too early or too late and fail those checks.

It applies the opposite edge in each edge mode, where a design with the polarity swapped would raise a request. It holds the acknowledge during a level request, where a design that latched levels would drop the request. It also sets the trigger write and the acknowledge in the same cycle, where a design with clear-over-set priority would lose the software request.

It changes the source code while an edge request is pending and then restores it. A design that kept stale pending state would bring the request back. Unselected peripheral lines and disabled codes are driven active to show that they cannot leak into the request.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

    typedef enum logic [1:0] {
        XT_BLOCK  = 2'b00,
        XT_STEP   = 2'b01,
        XT_BURST  = 2'b10,
        XT_DEMAND = 2'b11
    } xfer_type_t;

    typedef enum logic [1:0] {
        EX_OFF   = 2'b00,
        EX_WATCH = 2'b01,
        EX_PEND  = 2'b10
    } ext_state_t;

    typedef enum logic {
        SW_IDLE  = 1'b0,
        SW_ARMED = 1'b1
    } sw_state_t;

    // Pin codes: low bit chooses polarity (0: falling/high, 1: rising/low)
    localparam int unsigned PIN_CODE_A = 14;
    localparam int unsigned PIN_CODE_B = 15;

endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_sync,
    output logic pin_prev
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= pin_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) pin_prev <= 1'b0;
        else        pin_prev <= chain[STAGES-1];
    end

    assign pin_sync = chain[STAGES-1];
endmodule

// File: rtl/dma_req_src_decode.sv
module dma_req_src_decode
    import dma_req_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [IDX_W:0] src_sel,
    input  logic [1:0]     xfer_type,
    output logic           edge_mode,
    output logic           level_mode,
    output logic           pin_pol,
    output logic           per_sel,
    output logic [IDX_W-1:0] per_idx
);
    xfer_type_t xt;
    logic       pin_code;

    always_comb begin
        xt         = xfer_type_t'(xfer_type);
        pin_code   = (src_sel == (IDX_W+1)'(PIN_CODE_A)) ||
                     (src_sel == (IDX_W+1)'(PIN_CODE_B));
        pin_pol    = src_sel[0];
        per_sel    = src_sel[IDX_W];
        per_idx    = src_sel[IDX_W-1:0];
        edge_mode  = 1'b0;
        level_mode = 1'b0;
        if (pin_code) begin
            unique case (xt)
                XT_BLOCK, XT_STEP, XT_BURST: edge_mode  = 1'b1;
                XT_DEMAND:                   level_mode = 1'b1;
                default:                     edge_mode  = 1'b0;
            endcase
        end
    end

    // R8 / R7: the two hardware paths never both selected
    always_comb begin
        a_r7_exclusive: assert (!(per_sel && (edge_mode || level_mode)));
    end
endmodule

// File: rtl/dma_req_ext_detect.sv
module dma_req_ext_detect
    import dma_req_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic edge_mode,
    input  logic level_mode,
    input  logic pin_pol,
    input  logic pin_sync,
    input  logic pin_prev,
    input  logic req_ack,
    output logic ext_req
);
    ext_state_t state, state_nxt;
    logic       edge_hit;
    logic       level_hit;

    always_comb begin
        edge_hit  = pin_pol ? (!pin_prev && pin_sync) : (pin_prev && !pin_sync);
        level_hit = level_mode && (pin_sync ^ pin_pol);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= EX_OFF;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            EX_OFF: begin
                if (edge_mode) state_nxt = EX_WATCH;
            end
            EX_WATCH: begin
                if (!edge_mode)    state_nxt = EX_OFF;
                else if (edge_hit) state_nxt = EX_PEND;
            end
            EX_PEND: begin
                if (!edge_mode)                state_nxt = EX_OFF;
                else if (req_ack && !edge_hit) state_nxt = EX_WATCH;
            end
            default: state_nxt = EX_OFF;
        endcase
    end

    always_comb begin
        ext_req = level_hit || ((state == EX_PEND) && edge_mode);
    end

    a_r2_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == EX_PEND && edge_mode && !req_ack) |=> (state == EX_PEND));

    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (state == EX_PEND && edge_mode && req_ack && !edge_hit) |=> (state == EX_WATCH));

    a_r11_leave_discards: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_mode) |=> (state == EX_OFF || state == EX_WATCH) && state != EX_PEND);
endmodule

// File: rtl/dma_req_sw_trig.sv
module dma_req_sw_trig
    import dma_req_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_trig_wr,
    input  logic req_ack,
    output logic sw_req
);
    sw_state_t state, state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SW_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            SW_IDLE:  if (sw_trig_wr)              state_nxt = SW_ARMED;
            SW_ARMED: if (req_ack && !sw_trig_wr)  state_nxt = SW_IDLE;
            default:  state_nxt = SW_IDLE;
        endcase
    end

    always_comb begin
        sw_req = (state == SW_ARMED);
    end

    a_r9_sw_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && !req_ack) |=> sw_req);

    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        sw_trig_wr |=> sw_req);
endmodule

// File: rtl/dma_req_select.sv
module dma_req_select
    import dma_req_pkg::*;
#(
    parameter int IDX_W       = 4,
    parameter int SYNC_STAGES = 2,
    localparam int LINES      = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W:0]   src_sel,
    input  logic [1:0]       xfer_type,
    input  logic             ext_pin,
    input  logic [LINES-1:0] periph_irq,
    input  logic             sw_trig_wr,
    input  logic             req_ack,
    output logic             dma_req
);
    logic             edge_mode, level_mode, pin_pol, per_sel;
    logic [IDX_W-1:0] per_idx;
    logic             pin_sync, pin_prev;
    logic             ext_req, sw_req, per_req;
    logic [LINES-1:0] per_hits;

    dma_req_src_decode #(.IDX_W(IDX_W)) u_decode (
        .src_sel    (src_sel),
        .xfer_type  (xfer_type),
        .edge_mode  (edge_mode),
        .level_mode (level_mode),
        .pin_pol    (pin_pol),
        .per_sel    (per_sel),
        .per_idx    (per_idx)
    );

    dma_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (ext_pin),
        .pin_sync  (pin_sync),
        .pin_prev  (pin_prev)
    );

    dma_req_ext_detect u_ext (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_mode  (edge_mode),
        .level_mode (level_mode),
        .pin_pol    (pin_pol),
        .pin_sync   (pin_sync),
        .pin_prev   (pin_prev),
        .req_ack    (req_ack),
        .ext_req    (ext_req)
    );

    dma_req_sw_trig u_sw (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_trig_wr (sw_trig_wr),
        .req_ack    (req_ack),
        .sw_req     (sw_req)
    );

    generate
        for (genvar l = 0; l < LINES; l++) begin : g_line
            assign per_hits[l] = per_sel && (per_idx == IDX_W'(l)) && periph_irq[l];
        end
    endgenerate

    always_comb begin
        per_req = |per_hits;
        dma_req = ext_req || per_req || sw_req;
    end

    a_r7_periph_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel[IDX_W] && !sw_req) |-> (dma_req == periph_irq[src_sel[IDX_W-1:0]]));

    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_sel[IDX_W] && src_sel != (IDX_W+1)'(PIN_CODE_A) &&
         src_sel != (IDX_W+1)'(PIN_CODE_B) && !sw_req) |-> !dma_req);
endmodule

// File: tb/dma_req_select_tb.sv
module dma_req_select_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  src_sel;
    logic [1:0]  xfer_type;
    logic        ext_pin;
    logic [15:0] periph_irq;
    logic        sw_trig_wr;
    logic        req_ack;
    logic        dma_req;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_req_select dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_sel    (src_sel),
        .xfer_type  (xfer_type),
        .ext_pin    (ext_pin),
        .periph_irq (periph_irq),
        .sw_trig_wr (sw_trig_wr),
        .req_ack    (req_ack),
        .dma_req    (dma_req)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic ack_pulse();
        req_ack = 1'b1;
        tick(1);
        req_ack = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; src_sel = 5'b00000; xfer_type = 2'b00; ext_pin = 1'b0;
        periph_irq = '0; sw_trig_wr = 1'b0; req_ack = 1'b0;
        tick(3);
        check("R1 in reset", dma_req, 1'b0);
        rst_n = 1'b1;
        tick(1);
        check("R1 after reset", dma_req, 1'b0);
    endtask

    task automatic t_fall_edge();
        src_sel = 5'b01110; xfer_type = 2'b00;
        tick(2);
        ext_pin = 1'b1; tick(4);
        check("R2 rising edge ignored", dma_req, 1'b0);
        ext_pin = 1'b0; tick(2);
        check("R2 not yet after 2 edges", dma_req, 1'b0);
        tick(1);
        check("R2 falling edge request", dma_req, 1'b1);
        tick(4);
        check("R2 request held", dma_req, 1'b1);
        ack_pulse();
        check("R4 ack clears edge", dma_req, 1'b0);
        tick(3);
        check("R4 stays clear", dma_req, 1'b0);
    endtask

    task automatic t_rise_edge();
        src_sel = 5'b01111; xfer_type = 2'b10;
        tick(2);
        ext_pin = 1'b1; tick(3);
        check("R3 rising edge request", dma_req, 1'b1);
        ack_pulse();
        check("R4 ack clears rise", dma_req, 1'b0);
        ext_pin = 1'b0; tick(4);
        check("R3 falling edge ignored", dma_req, 1'b0);
    endtask

    task automatic t_leave_edge();
        src_sel = 5'b01111; xfer_type = 2'b01;
        tick(2);
        ext_pin = 1'b1; tick(3);
        check("R11 pending before leave", dma_req, 1'b1);
        src_sel = 5'b00000; #1;
        check("R11 dropped on leave", dma_req, 1'b0);
        tick(2);
        src_sel = 5'b01111; tick(3);
        check("R11 not restored", dma_req, 1'b0);
        ext_pin = 1'b0; tick(3);
    endtask

    task automatic t_level_high();
        src_sel = 5'b01110; xfer_type = 2'b11; ext_pin = 1'b0;
        tick(3);
        check("R5 low pin no request", dma_req, 1'b0);
        ext_pin = 1'b1; tick(1);
        check("R5 one edge not yet", dma_req, 1'b0);
        tick(1);
        check("R5 high level request", dma_req, 1'b1);
        req_ack = 1'b1; tick(2);
        check("R5 ack does not lower", dma_req, 1'b1);
        req_ack = 1'b0;
        ext_pin = 1'b0; tick(2);
        check("R5 follows pin low", dma_req, 1'b0);
    endtask

    task automatic t_level_low();
        src_sel = 5'b01111; xfer_type = 2'b11; ext_pin = 1'b0;
        tick(2);
        check("R6 low level request", dma_req, 1'b1);
        ext_pin = 1'b1; tick(2);
        check("R6 high pin no request", dma_req, 1'b0);
        ext_pin = 1'b0; tick(3);
    endtask

    task automatic t_periph();
        src_sel = 5'b10011; xfer_type = 2'b00; ext_pin = 1'b0;
        periph_irq = 16'h0008; #1;
        check("R7 selected line", dma_req, 1'b1);
        periph_irq = 16'hFFF7; #1;
        check("R7 other lines ignored", dma_req, 1'b0);
        periph_irq = '0;
        ext_pin = 1'b1; tick(4);
        check("R7 pin ignored", dma_req, 1'b0);
        ext_pin = 1'b0; tick(4);
        check("R7 pin fall ignored", dma_req, 1'b0);
        src_sel = 5'b11111; periph_irq = 16'h8000; #1;
        check("R7 top line", dma_req, 1'b1);
        periph_irq = '0; tick(1);
    endtask

    task automatic t_disabled();
        src_sel = 5'b01101; xfer_type = 2'b11; periph_irq = 16'hFFFF;
        ext_pin = 1'b1; tick(4);
        check("R8 code 01101 quiet", dma_req, 1'b0);
        xfer_type = 2'b00; ext_pin = 1'b0; tick(4);
        check("R8 edge quiet", dma_req, 1'b0);
        src_sel = 5'b00000; ext_pin = 1'b1; tick(4);
        check("R8 code 00000 quiet", dma_req, 1'b0);
        ext_pin = 1'b0; periph_irq = '0; tick(3);
    endtask

    task automatic t_sw();
        src_sel = 5'b00000; xfer_type = 2'b11;
        sw_trig_wr = 1'b1; tick(1); sw_trig_wr = 1'b0;
        check("R9 sw request", dma_req, 1'b1);
        tick(5);
        check("R9 sw held", dma_req, 1'b1);
        ack_pulse();
        check("R9 ack clears sw", dma_req, 1'b0);
        src_sel = 5'b10010; periph_irq = '0;
        sw_trig_wr = 1'b1; tick(1); sw_trig_wr = 1'b0;
        check("R9 sw under periph code", dma_req, 1'b1);
        sw_trig_wr = 1'b1; req_ack = 1'b1; tick(1);
        sw_trig_wr = 1'b0; req_ack = 1'b0;
        check("R10 write beats ack", dma_req, 1'b1);
        ack_pulse();
        check("R10 later ack clears", dma_req, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_fall_edge();
        t_rise_edge();
        t_leave_edge();
        t_level_high();
        t_level_low();
        t_periph();
        t_disabled();
        t_sw();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule